// File: doc/BRIEF.md
# Virtual machine branch resolution and next-PC unit

This block resolves control flow for the jump instructions of a 64-bit register virtual machine. Each cycle it takes one decoded instruction (the 8-bit opcode, the 16-bit offset field, the 32-bit immediate field and the 4-bit source-register field), the values of the destination and source registers, and the current program counter. The program counter counts 64-bit instruction slots. One clock edge later it presents the next PC, a taken flag, call and exit indications with the kind of call, and an illegal flag.

Two classes are handled. The wide class compares full 64-bit operands. The narrow class compares only the low 32 bits. Conditions cover equality, inequality, a bit test, and unsigned and signed orderings. The unconditional jump takes its displacement from the offset field in the wide class and from the immediate field in the narrow class. Calls are only flagged, together with their kind. For a call to a function inside the same program, the unit also computes the target. Dispatching calls to helpers and keeping a return stack are left to neighbouring logic.

Top module: `vmbr_pcu`

## Requirements
- R1: While `rst_n` is low, all outputs are zero. This holds at power-up and also when reset is asserted in the middle of a run.
- R2: The opcode is split into three fields. Bits [2:0] give the class: 5 is wide, 6 is narrow. Bit 3 chooses the second operand: 1 selects `src_val`, 0 selects the sign-extended immediate. Bits [7:4] give the condition code. Code 1 branches when the operands are equal, code 5 when they differ, and code 4 when their bitwise AND is nonzero.
- R3: Unsigned conditions are code 2 (greater), code 3 (greater or equal), code 0xa (less) and code 0xb (less or equal).
- R4: Signed (two's complement) conditions are code 6 (greater), code 7 (greater or equal), code 0xc (less) and code 0xd (less or equal).
- R5: The narrow class compares only bits [31:0] of both operands. Its signed conditions treat those 32 bits as a signed 32-bit value. For example, opcode 0x7e is a signed greater-or-equal test on the low halves of two registers.
- R6: When a conditional branch is taken, `pc_next` is pc + 1 + the sign-extended offset field. When it is not taken, `pc_next` is pc + 1. Both sums wrap modulo 2^PC_W.
- R7: Code 0 is an unconditional jump and is always taken. In the wide class the displacement is the sign-extended offset field. In the narrow class it is the 32-bit immediate.
- R8: Code 8 is a call in either class. It raises `is_call`, and `call_kind` copies the source-register field, where 0 means a helper by address, 1 a local function and 2 a helper by type ID. A local call is taken to pc + 1 + offset. A helper call is not taken and gives pc + 1. A source field above 2 makes the call illegal.
- R9: Code 9 is an exit. In the wide class it raises `is_exit`, is not taken and gives pc + 1. In the narrow class it is illegal.
- R10: An illegal instruction raises only `illegal`. It is not taken, `call_kind` is 0 and `pc_next` is pc + 1. The illegal cases are codes 0xe and 0xf, any class other than 5 or 6, and the cases in R8 and R9.
- R11: The outputs are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 8 | Instruction opcode |
| off_field | input | 16 | Signed offset field |
| imm_field | input | 32 | Signed immediate field |
| src_sel | input | 4 | Source-register field (call kind for calls) |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| pc_cur | input | PC_W | Current PC in instruction slots |
| pc_next | output | PC_W | Resolved next PC |
| taken | output | 1 | Control transfer away from the sequential slot |
| is_call | output | 1 | Instruction is a call |
| is_exit | output | 1 | Instruction is an exit |
| call_kind | output | 2 | Kind of call |
| illegal | output | 1 | Instruction is not a valid jump-class encoding |

## Verification
The assertions take for granted that the inputs are held steady around each rising edge. The relations that use `$past` also assume that the values sampled at one edge are the ones the registers captured. The bench therefore changes every input only on the falling edge and releases reset on a falling edge. The properties that link `is_exit`, `call_kind` and the sequential PC to the previous opcode, source field and PC are then evaluated against exactly the instruction that produced them.

// File: rtl/vmbr_pkg.sv
package vmbr_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned IMM_W  = 32;
    localparam int unsigned OFF_W  = 16;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        J_ALWAYS = 4'h0,
        J_EQ     = 4'h1,
        J_UGT    = 4'h2,
        J_UGE    = 4'h3,
        J_BITS   = 4'h4,
        J_NE     = 4'h5,
        J_SGT    = 4'h6,
        J_SGE    = 4'h7,
        J_CALL   = 4'h8,
        J_EXIT   = 4'h9,
        J_ULT    = 4'ha,
        J_ULE    = 4'hb,
        J_SLT    = 4'hc,
        J_SLE    = 4'hd,
        J_RES_E  = 4'he,
        J_RES_F  = 4'hf
    } jcode_e;

    typedef enum logic [1:0] {
        K_HELPER_ADDR = 2'd0,
        K_LOCAL       = 2'd1,
        K_HELPER_ID   = 2'd2
    } ckind_e;

endpackage

// File: rtl/vmbr_opsel.sv
module vmbr_opsel
    import vmbr_pkg::*;
(
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              use_reg,
    input  logic              narrow,
    output logic [DATA_W-1:0] a_sx,
    output logic [DATA_W-1:0] b_sx,
    output logic [DATA_W-1:0] a_zx,
    output logic [DATA_W-1:0] b_zx
);
    logic [DATA_W-1:0] b_raw;

    always_comb begin
        b_raw = use_reg ? src_val
                        : {{(DATA_W-IMM_W){imm_field[IMM_W-1]}}, imm_field};
        if (narrow) begin
            a_zx = {{(DATA_W-HALF_W){1'b0}}, dst_val[HALF_W-1:0]};
            b_zx = {{(DATA_W-HALF_W){1'b0}}, b_raw[HALF_W-1:0]};
            a_sx = {{(DATA_W-HALF_W){dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
            b_sx = {{(DATA_W-HALF_W){b_raw[HALF_W-1]}}, b_raw[HALF_W-1:0]};
        end else begin
            a_zx = dst_val;
            b_zx = b_raw;
            a_sx = dst_val;
            b_sx = b_raw;
        end
    end
endmodule

// File: rtl/vmbr_cond.sv
module vmbr_cond
    import vmbr_pkg::*;
(
    input  jcode_e            code,
    input  logic [DATA_W-1:0] a_sx,
    input  logic [DATA_W-1:0] b_sx,
    input  logic [DATA_W-1:0] a_zx,
    input  logic [DATA_W-1:0] b_zx,
    output logic              is_cond,
    output logic              hit
);
    logic eq, ult, slt, bits;

    always_comb begin
        eq   = (a_zx == b_zx);
        ult  = (a_zx < b_zx);
        slt  = ($signed(a_sx) < $signed(b_sx));
        bits = |(a_zx & b_zx);
        is_cond = 1'b1;
        hit     = 1'b0;
        unique case (code)
            J_EQ:    hit = eq;
            J_NE:    hit = !eq;
            J_BITS:  hit = bits;
            J_UGT:   hit = !ult && !eq;
            J_UGE:   hit = !ult;
            J_ULT:   hit = ult;
            J_ULE:   hit = ult || eq;
            J_SGT:   hit = !slt && !eq;
            J_SGE:   hit = !slt;
            J_SLT:   hit = slt;
            J_SLE:   hit = slt || eq;
            default: is_cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/vmbr_target.sv
module vmbr_target #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned DISP_W = 32
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    logic [PC_W-1:0] disp_ext;

    generate
        if (PC_W > DISP_W) begin : g_widen
            assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else if (PC_W == DISP_W) begin : g_same
            assign disp_ext = disp;
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    assign target = pc + disp_ext + PC_W'(1);
endmodule

// File: rtl/vmbr_pcu.sv
module vmbr_pcu
    import vmbr_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           op_code,
    input  logic [OFF_W-1:0]     off_field,
    input  logic [IMM_W-1:0]     imm_field,
    input  logic [3:0]           src_sel,
    input  logic [DATA_W-1:0]    dst_val,
    input  logic [DATA_W-1:0]    src_val,
    input  logic [PC_W-1:0]      pc_cur,
    output logic [PC_W-1:0]      pc_next,
    output logic                 taken,
    output logic                 is_call,
    output logic                 is_exit,
    output logic [1:0]           call_kind,
    output logic                 illegal
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            tk;
        logic            call;
        logic            exit;
        logic [1:0]      kind;
        logic            ill;
    } res_t;

    res_t   res_d, res_q;
    logic   wide, narrow;
    jcode_e code;
    logic [DATA_W-1:0] a_sx, b_sx, a_zx, b_zx;
    logic   is_cond, hit;
    logic [IMM_W-1:0] disp;
    logic [PC_W-1:0]  tgt, seq_pc;

    assign wide   = (op_code[2:0] == CLS_WIDE);
    assign narrow = (op_code[2:0] == CLS_NARROW);
    assign code   = jcode_e'(op_code[7:4]);

    vmbr_opsel u_opsel (
        .dst_val   (dst_val),
        .src_val   (src_val),
        .imm_field (imm_field),
        .use_reg   (op_code[3]),
        .narrow    (narrow),
        .a_sx      (a_sx),
        .b_sx      (b_sx),
        .a_zx      (a_zx),
        .b_zx      (b_zx)
    );

    vmbr_cond u_cond (
        .code    (code),
        .a_sx    (a_sx),
        .b_sx    (b_sx),
        .a_zx    (a_zx),
        .b_zx    (b_zx),
        .is_cond (is_cond),
        .hit     (hit)
    );

    // Only the narrow-class unconditional jump uses the immediate as displacement
    assign disp = (narrow && code == J_ALWAYS) ? imm_field
                : {{(IMM_W-OFF_W){off_field[OFF_W-1]}}, off_field};

    vmbr_target #(.PC_W(PC_W), .DISP_W(IMM_W)) u_target (
        .pc     (pc_cur),
        .disp   (disp),
        .target (tgt)
    );

    assign seq_pc = pc_cur + PC_W'(1);

    always_comb begin
        res_d      = '0;
        res_d.pc   = seq_pc;
        if (!(wide || narrow)) begin
            res_d.ill = 1'b1;
        end else if (is_cond) begin
            res_d.tk = hit;
            res_d.pc = hit ? tgt : seq_pc;
        end else begin
            unique case (code)
                J_ALWAYS: begin
                    res_d.tk = 1'b1;
                    res_d.pc = tgt;
                end
                J_CALL: begin
                    if (src_sel > 4'd2) begin
                        res_d.ill = 1'b1;
                    end else begin
                        res_d.call = 1'b1;
                        res_d.kind = src_sel[1:0];
                        if (ckind_e'(src_sel[1:0]) == K_LOCAL) begin
                            res_d.tk = 1'b1;
                            res_d.pc = tgt;
                        end
                    end
                end
                J_EXIT: begin
                    if (wide) res_d.exit = 1'b1;
                    else      res_d.ill  = 1'b1;
                end
                default: res_d.ill = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign pc_next   = res_q.pc;
    assign taken     = res_q.tk;
    assign is_call   = res_q.call;
    assign is_exit   = res_q.exit;
    assign call_kind = res_q.kind;
    assign illegal   = res_q.ill;

    // R10: call, exit and illegal never coexist
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_call, is_exit, illegal}));

    // R10: illegal results are quiet and sequential
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && call_kind == 2'd0 && pc_next == $past(pc_cur) + PC_W'(1)));

    // R9: exit only from the wide class, never taken
    p_exit_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_exit |-> (!taken && $past(op_code[2:0]) == CLS_WIDE));

    // R8: reported kind matches the source field of the call
    p_call_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_call |-> (call_kind == $past(src_sel[1:0])));

    // R7: an unconditional jump in a jump class is taken one edge later
    p_ja_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[7:4] == 4'h0 && (op_code[2:0] == CLS_WIDE || op_code[2:0] == CLS_NARROW))
        |=> taken);

    // R6: a not-taken helper call steps to the next slot
    p_helper_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_call && !taken) |-> (pc_next == $past(pc_cur) + PC_W'(1)));

endmodule

// File: tb/vmbr_pcu_bench.sv
module vmbr_pcu_bench;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] off;
        logic [31:0] imm;
        logic [3:0]  srcf;
        logic [63:0] dv;
        logic [63:0] sv;
        logic [31:0] pc;
        logic [31:0] epc;
        logic        etk;
        logic        ecall;
        logic        eexit;
        logic        eill;
        logic [1:0]  ekind;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam vec_t VECS [NV] = '{
        // R2 equality, bit test
        '{8'h1d, 16'd5,     32'd0,          4'd0, 64'd7,  64'd7, 32'd100, 32'd106, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd2},
        '{8'h1d, 16'd5,     32'd0,          4'd0, 64'd7,  64'd8, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd2},
        '{8'h55, 16'd5,     32'd3,          4'd0, 64'd3,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd2},
        '{8'h45, 16'hFFFE,  32'h10,         4'd0, 64'h30, 64'd0, 32'd100, 32'd99,  1'b1,1'b0,1'b0,1'b0,2'd0,4'd2},
        // R3 unsigned, R4 signed
        '{8'h2d, 16'd4,     32'd0,          4'd0, ONES,   64'd1, 32'd100, 32'd105, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd3},
        '{8'h6d, 16'd4,     32'd0,          4'd0, ONES,   64'd1, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},
        '{8'ha5, 16'd10,    32'hFFFF_FFFF,  4'd0, 64'd5,  64'd0, 32'd100, 32'd111, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd3},
        '{8'hc5, 16'd10,    32'hFFFF_FFFF,  4'd0, 64'd5,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},
        '{8'h3d, 16'd1,     32'd0,          4'd0, 64'd9,  64'd9, 32'd100, 32'd102, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd3},
        '{8'hbd, 16'd1,     32'd0,          4'd0, 64'd10, 64'd9, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd3},
        '{8'h7d, 16'd2,     32'd0,          4'd0, 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, 32'd100, 32'd103, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd4},
        '{8'hdd, 16'd3,     32'd0,          4'd0, 64'hFFFF_FFFF_FFFF_FFFA, 64'hFFFF_FFFF_FFFF_FFFB, 32'd100, 32'd104, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd4},
        // R5 narrow class compares low halves
        '{8'h1e, 16'd7,     32'd0,          4'd0, 64'hAAAA_0000_0000_0001, 64'h5555_0000_0000_0001, 32'd100, 32'd108, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd5},
        '{8'h1d, 16'd7,     32'd0,          4'd0, 64'hAAAA_0000_0000_0001, 64'h5555_0000_0000_0001, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd5},
        '{8'h7e, 16'd7,     32'd0,          4'd0, 64'h0000_0000_8000_0000, 64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd5},
        '{8'h7d, 16'd7,     32'd0,          4'd0, 64'h0000_0000_8000_0000, 64'd0, 32'd100, 32'd108, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd5},
        '{8'h26, 16'd1,     32'd1,          4'd0, 64'hFFFF_FFFF_0000_0002, 64'd0, 32'd100, 32'd102, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd5},
        // R7 unconditional jumps
        '{8'h05, 16'hFFF0,  32'd0,          4'd0, 64'd0,  64'd0, 32'd100, 32'd85,  1'b1,1'b0,1'b0,1'b0,2'd0,4'd7},
        '{8'h06, 16'd5,     32'h0001_0000,  4'd0, 64'd0,  64'd0, 32'd100, 32'd65637, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd7},
        // R6 wrap on taken and not-taken
        '{8'h06, 16'd0,     32'hFFFF_FC00,  4'd0, 64'd0,  64'd0, 32'd1000, 32'hFFFF_FFE9, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd6},
        // R8 calls
        '{8'h85, 16'd0,     32'd42,         4'd0, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b1,1'b0,1'b0,2'd0,4'd8},
        '{8'h85, 16'd20,    32'd0,          4'd1, 64'd0,  64'd0, 32'd100, 32'd121, 1'b1,1'b1,1'b0,1'b0,2'd1,4'd8},
        '{8'h85, 16'd0,     32'd7,          4'd2, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b1,1'b0,1'b0,2'd2,4'd8},
        '{8'h85, 16'd0,     32'd7,          4'd3, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b1,2'd0,4'd8},
        // R9 exits
        '{8'h95, 16'd0,     32'd0,          4'd0, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd9},
        '{8'h96, 16'd0,     32'd0,          4'd0, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b1,2'd0,4'd9},
        // R10 undefined code and foreign class
        '{8'he5, 16'd9,     32'd0,          4'd0, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b1,2'd0,4'd10},
        '{8'h07, 16'd9,     32'd0,          4'd0, 64'd0,  64'd0, 32'd100, 32'd101, 1'b0,1'b0,1'b0,1'b1,2'd0,4'd10},
        // R6 wrap at top of PC space
        '{8'h05, 16'd0,     32'd0,          4'd0, 64'd0,  64'd0, 32'hFFFF_FFFF, 32'd0, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd6},
        '{8'h1d, 16'd4,     32'd0,          4'd0, 64'd1,  64'd2, 32'hFFFF_FFFF, 32'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd6},
        // R8 local call from narrow class
        '{8'h86, 16'd2,     32'd0,          4'd1, 64'd0,  64'd0, 32'd100, 32'd103, 1'b1,1'b1,1'b0,1'b0,2'd1,4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_code = '0;
    logic [15:0] off_field = '0;
    logic [31:0] imm_field = '0;
    logic [3:0]  src_sel = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] pc_cur = '0;
    logic [31:0] pc_next;
    logic        taken, is_call, is_exit, illegal;
    logic [1:0]  call_kind;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vmbr_pcu #(.PC_W(32)) u_vmbr_pcu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .off_field (off_field),
        .imm_field (imm_field),
        .src_sel   (src_sel),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .pc_cur    (pc_cur),
        .pc_next   (pc_next),
        .taken     (taken),
        .is_call   (is_call),
        .is_exit   (is_exit),
        .call_kind (call_kind),
        .illegal   (illegal)
    );

    task automatic drive(input vec_t v);
        op_code   = v.op;
        off_field = v.off;
        imm_field = v.imm;
        src_sel   = v.srcf;
        dst_val   = v.dv;
        src_val   = v.sv;
        pc_cur    = v.pc;
    endtask

    task automatic check_out(input string tag, input logic [31:0] epc, input logic etk,
                             input logic ecall, input logic eexit, input logic eill,
                             input logic [1:0] ekind);
        checks++;
        if (pc_next !== epc || taken !== etk || is_call !== ecall || is_exit !== eexit ||
            illegal !== eill || call_kind !== ekind) begin
            errors++;
            $display("FAIL %s: got pc=%h tk=%b call=%b exit=%b ill=%b kind=%0d, expected pc=%h tk=%b call=%b exit=%b ill=%b kind=%0d",
                     tag, pc_next, taken, is_call, is_exit, illegal, call_kind,
                     epc, etk, ecall, eexit, eill, ekind);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero under reset despite active stimulus
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        #2 check_out("R1 reset", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(posedge clk);
            #2 check_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                         VECS[i].epc, VECS[i].etk, VECS[i].ecall, VECS[i].eexit,
                         VECS[i].eill, VECS[i].ekind);
        end

        // R11: output changes only at the rising edge
        @(negedge clk);
        drive('{8'h05, 16'd3, 32'd0, 4'd0, 64'd0, 64'd0, 32'd10, 32'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0});
        @(posedge clk);
        #2 check_out("R11 first", 32'd14, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        drive('{8'h1d, 16'd3, 32'd0, 4'd0, 64'd1, 64'd2, 32'd50, 32'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0});
        #1 check_out("R11 held", 32'd14, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
        @(posedge clk);
        #2 check_out("R11 updated", 32'd51, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);

        // R1: reset asserted mid-run clears immediately
        @(negedge clk);
        drive('{8'h85, 16'd0, 32'd0, 4'd2, 64'd0, 64'd0, 32'd7, 32'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0});
        @(posedge clk);
        #2 check_out("R8 pre-reset call", 32'd8, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
        @(negedge clk) rst_n = 1'b0;
        #1 check_out("R1 mid-run reset", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #2 check_out("R1 after release", 32'd8, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule